// File: doc/BRIEF.md
# Flow-Through Burst Static RAM

This block is a single-clock synchronous word memory, 32 bits wide with a parameterised depth. Every input (address, write data, byte-lane controls, burst controls and selects) is captured on the rising clock edge. Read data then comes straight out of the array, addressed by the captured address, in the cycle that follows that edge. No output register sits on the read path.

A 2-bit burst counter generates up to four consecutive accesses from one loaded address. A load input starts a burst and an advance input steps it. An order input, sampled when the burst is loaded, picks a linear or an interleaved visiting order. Writes can change any subset of the four byte lanes, and a global write forces all four lanes. The shared data bus is modelled as separate in and out vectors plus a drive-enable flag. The flag is low during write cycles and while the device is not selected.

Top module: `fthru_burst_ram`

## Requirements
- R1: While reset is held, and in the first cycle after it, `bus_drive` is 0 and `rd_data` is all zeros.
- R2: A selected read cycle whose controls are captured at edge N shows the addressed word on `rd_data` with `bus_drive` = 1 before edge N+1. There is no additional pipeline cycle.
- R3: A selected cycle with `adr_load` = 1 takes `adr` as the burst base and clears the burst count to 0. It also captures `order_sel` as the burst order. `adr_load` wins over `advance` when both are high.
- R4: With order 0, the low two bits of the accessed address are (base low bits + count) modulo 4. The upper bits are those of the base.
- R5: With order 1, the low two bits of the accessed address are base low bits XOR count.
- R6: A selected cycle with `advance` = 1 and `adr_load` = 0 adds one to the burst count, modulo 4. After four accesses the burst returns to the base. With neither input high, the same address is accessed again.
- R7: With `gwr_n` = 1 and `bwr_n` = 0, a write updates exactly the lanes whose `lane_n` bit is 0. Lane i is bits [8i+7:8i]. The write goes to the accessed address of the captured cycle and is visible from the next cycle.
- R8: With `gwr_n` = 0, all four lanes are written, whatever `bwr_n` and `lane_n` are.
- R9: With `gwr_n` = 1 and `bwr_n` = 1, the cycle is a read and the array is unchanged.
- R10: The device is selected only when `sel_p` = 1, `sel_an` = 0 and `sel_bn` = 0. In the cycle after an unselected edge, `bus_drive` is 0 and `rd_data` is zero. That edge writes nothing, and its load and advance leave the burst state unchanged.
- R11: In the cycle after a selected write edge, `bus_drive` is 0 and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control registers |
| sel_p | input | 1 | Active-high select |
| sel_an | input | 1 | Active-low select A |
| sel_bn | input | 1 | Active-low select B |
| adr_load | input | 1 | Start a burst at `adr` |
| advance | input | 1 | Step the burst count |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| adr | input | ADR_W | Word address |
| gwr_n | input | 1 | Active-low global write (all lanes) |
| bwr_n | input | 1 | Active-low byte write enable |
| lane_n | input | 4 | Active-low per-lane write strobes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Flow-through read data, zero when not driving |
| bus_drive | output | 1 | High when the block would drive the shared bus |

## Verification
On every cycle, assertions check how the burst state reacts: a load clears the count and takes the base, an advance steps the count by one modulo 4, and an unselected edge freezes the state and blocks writes. They also check that a global write selects all lanes. Only the bench's scenarios can show which array words and lanes a write actually changed, the two burst orders seen through read data, and the one-cycle flow-through timing. The bench shows these by comparing every cycle against a behavioural memory model.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // low two address bits of the current burst beat
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       interleave);
    return interleave ? (base ^ cnt) : (base + cnt);
  endfunction

  // lanes written by one captured cycle
  function automatic logic [LANES-1:0] lane_mask(input logic             gw_n,
                                                 input logic             bw_n,
                                                 input logic [LANES-1:0] strobe_n);
    if (!gw_n) return '1;
    if (!bw_n) return ~strobe_n;
    return '0;
  endfunction
endpackage

// File: rtl/fb_ctrl.sv
module fb_ctrl
  import fb_pkg::*;
#(
  parameter int ADR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_p,
  input  logic                 sel_an,
  input  logic                 sel_bn,
  input  logic                 adr_load,
  input  logic                 advance,
  input  logic                 order_sel,
  input  logic [ADR_W-1:0]     adr,
  input  logic                 gwr_n,
  input  logic                 bwr_n,
  input  logic [LANES-1:0]     lane_n,
  input  logic [WORD_W-1:0]    wr_data,
  output logic                 act_q,
  output logic [LANES-1:0]     wr_q,
  output logic [WORD_W-1:0]    wdat_q,
  output logic [ADR_W-1:0]     acc_adr
);
  logic             chip_sel;
  logic [ADR_W-1:0] base_q;
  logic [1:0]       cnt_q;
  logic             order_q;

  assign chip_sel = sel_p & ~sel_an & ~sel_bn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= '0;
      wdat_q  <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      order_q <= 1'b0;
    end else begin
      act_q <= chip_sel;
      if (chip_sel) begin
        wr_q   <= lane_mask(gwr_n, bwr_n, lane_n);
        wdat_q <= wr_data;
        if (adr_load) begin
          base_q  <= adr;
          cnt_q   <= '0;
          order_q <= order_sel;
        end else if (advance) begin
          cnt_q <= cnt_q + 2'd1;
        end
      end else begin
        wr_q <= '0;
      end
    end
  end

  assign acc_adr = {base_q[ADR_W-1:2], burst_low(base_q[1:0], cnt_q, order_q)};

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel && adr_load |=> cnt_q == 2'd0 && base_q == $past(adr));

  assert_advance_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel && !adr_load && advance |=> cnt_q == $past(cnt_q) + 2'd1);

  assert_deselect_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> !act_q && wr_q == '0 && $stable(cnt_q) && $stable(base_q));

  assert_global_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel && !gwr_n |=> wr_q == '1);
endmodule

// File: rtl/fb_array.sv
module fb_array
  import fb_pkg::*;
#(
  parameter int ADR_W = 8
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we_lanes,
  input  logic [ADR_W-1:0]  acc_adr,
  input  logic [WORD_W-1:0] wdat,
  output logic [WORD_W-1:0] rdat
);
  localparam int DEPTH = 1 << ADR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we_lanes[g]) cells[acc_adr] <= wdat[g*LANE_W +: LANE_W];
    end
    assign rdat[g*LANE_W +: LANE_W] = cells[acc_adr];
  end
endmodule

// File: rtl/fthru_burst_ram.sv
module fthru_burst_ram
  import fb_pkg::*;
#(
  parameter int ADR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_p,
  input  logic              sel_an,
  input  logic              sel_bn,
  input  logic              adr_load,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADR_W-1:0]  adr,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [3:0]        lane_n,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              bus_drive
);
  logic              act_q;
  logic [LANES-1:0]  wr_q;
  logic [WORD_W-1:0] wdat_q;
  logic [ADR_W-1:0]  acc_adr;
  logic [LANES-1:0]  we_lanes;
  logic [WORD_W-1:0] arr_rd;

  fb_ctrl #(.ADR_W(ADR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_p(sel_p), .sel_an(sel_an), .sel_bn(sel_bn),
    .adr_load(adr_load), .advance(advance), .order_sel(order_sel), .adr(adr),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n), .wr_data(wr_data),
    .act_q(act_q), .wr_q(wr_q), .wdat_q(wdat_q), .acc_adr(acc_adr)
  );

  assign we_lanes = act_q ? wr_q : '0;

  fb_array #(.ADR_W(ADR_W)) u_array (
    .clk(clk), .we_lanes(we_lanes), .acc_adr(acc_adr), .wdat(wdat_q), .rdat(arr_rd)
  );

  assign bus_drive = act_q & ~|wr_q;
  assign rd_data   = bus_drive ? arr_rd : '0;

  assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    |we_lanes |-> !bus_drive && rd_data == '0);
endmodule

// File: tb/fthru_burst_ram_test.sv
module fthru_burst_ram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_p = 1'b0, sel_an = 1'b1, sel_bn = 1'b1;
  logic        adr_load = 1'b0, advance = 1'b0, order_sel = 1'b0;
  logic [7:0]  adr = '0;
  logic        gwr_n = 1'b1, bwr_n = 1'b1;
  logic [3:0]  lane_n = 4'hF;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        bus_drive;

  always #2.5 clk = ~clk;

  fthru_burst_ram #(.ADR_W(8)) uut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural reference
  logic [31:0] ref_mem [256];
  bit          m_act = 0, m_order = 0;
  int          m_base = 0, m_cnt = 0;
  logic [3:0]  m_lanes = 0;
  logic [31:0] m_wd = 0;

  function automatic int ref_addr();
    int lo = m_order ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic check(input string tag, input logic [31:0] act_d, input logic act_b,
                       input logic [31:0] exp_d, input logic exp_b);
    checks++;
    if (act_d !== exp_d || act_b !== exp_b) begin
      fails++;
      $display("FAIL %s: rd_data=%h bus_drive=%b expected rd_data=%h bus_drive=%b",
               tag, act_d, act_b, exp_d, exp_b);
    end
  endtask

  // desel: 0 selected, 1..3 one select inactive
  task automatic step(input string tag, input int desel, input bit ld, input bit adv,
                      input bit ord, input int a, input bit gw, input bit bw,
                      input logic [3:0] ln, input logic [31:0] wd);
    sel_p = (desel != 1); sel_an = (desel == 2); sel_bn = (desel == 3);
    adr_load = ld; advance = adv; order_sel = ord; adr = a[7:0];
    gwr_n = gw; bwr_n = bw; lane_n = ln; wr_data = wd;
    @(posedge clk);
    #1;
    if (m_act) begin
      int ad = ref_addr();
      for (int i = 0; i < 4; i++)
        if (m_lanes[i]) ref_mem[ad][i*8 +: 8] = m_wd[i*8 +: 8];
    end
    m_act = (desel == 0);
    m_lanes = 0;
    if (m_act) begin
      if (ld) begin m_base = a; m_cnt = 0; m_order = ord; end
      else if (adv) m_cnt = (m_cnt + 1) % 4;
      if (!gw) m_lanes = 4'hF;
      else if (!bw) m_lanes = ~ln;
      m_wd = wd;
    end
    begin
      bit eb = m_act && (m_lanes == 0);
      check(tag, rd_data, bus_drive, eb ? ref_mem[ref_addr()] : 32'h0, eb);
    end
  endtask

  task automatic rd(input string tag, input bit ld, input bit adv, input bit ord, input int a);
    step(tag, 0, ld, adv, ord, a, 1, 1, 4'hF, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", rd_data, bus_drive, 32'h0, 1'b0);
    rst_n = 1'b1;
    step("R1 after reset", 1, 0, 0, 0, 0, 1, 1, 4'hF, 0);
    // fill array with global writes, lane strobes set to block (R8 override)
    for (int i = 0; i < 256; i++)
      step("R8 R11 fill", 0, 1, 0, 0, i, 0, 1, 4'hF, 32'hA5000000 ^ (i * 32'h01010101));
    // linear burst from base 6 with wrap
    rd("R2 R3 linear load", 1, 0, 0, 6);
    for (int k = 0; k < 4; k++) rd("R4 R6 linear advance", 0, 1, 0, 0);
    rd("R6 hold", 0, 0, 0, 0);
    // interleaved burst from base 0x2F
    rd("R3 R5 interleave load", 1, 0, 1, 8'h2F);
    for (int k = 0; k < 4; k++) rd("R5 R6 interleave advance", 0, 1, 0, 0);
    // load wins over advance
    rd("R3 load priority", 1, 1, 0, 8'h41);
    // byte writes within a burst, lanes 0 and 2
    step("R7 R11 byte write", 0, 1, 0, 0, 8'h80, 1, 0, 4'b1010, 32'h11223344);
    step("R7 byte write adv", 0, 0, 1, 0, 0, 1, 0, 4'b0111, 32'hDEADBEEF);
    rd("R7 readback", 1, 0, 0, 8'h80);
    rd("R7 readback next", 0, 1, 0, 0);
    // global write override with byte enable inactive
    step("R8 global", 0, 1, 0, 0, 8'h90, 0, 1, 4'b1110, 32'hCAFEF00D);
    rd("R8 readback", 1, 0, 0, 8'h90);
    // read-only cycle with data driven
    step("R9 no write", 0, 0, 0, 0, 0, 1, 1, 4'h0, 32'h0BADF00D);
    rd("R9 readback", 0, 0, 0, 0);
    // deselect by each select, with load, advance and write attempted
    rd("R10 setup", 1, 0, 0, 8'hC1);
    for (int d = 1; d <= 3; d++) begin
      step("R10 deselected", d, 1, 1, 1, 8'h10, 0, 0, 4'h0, 32'hFFFFFFFF);
      rd("R10 state kept", 0, 0, 0, 0);
    end
    rd("R10 advance after", 0, 1, 0, 0);
    rd("R10 word 0x10 intact", 1, 0, 0, 8'h10);
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule